// File: doc/BRIEF.md
# Modulo-13 Counter with Decoded Zero-Load

This block is a single-clock counter that produces thirteen distinct states, 0 through 12, and then starts again at 0. It is built on a plain 4-bit binary incrementer. The modulus does not come from a comparator on a limit register or from the natural binary wrap. A decode gate watches the value the incrementer is about to produce. When that value would be the first state outside the wanted range (13, binary 1101), the gate forces a load of zero on that same clock edge. State 13 therefore never reaches the output register.

A synchronous clear input is ORed into the same zero-load path, so either source resets the count. A terminal flag marks the last legal state, for cascading a following stage or for using the counter as a divide-by-13. The chip reset is asynchronous and active-low. Its release is passed through a short synchronizer before it reaches the count register.

Top module: `mod13_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `tc` is 0 at once, with no clock edge needed.
- R2: After `rst_n` goes high, `count` stays at 0 over the first two rising edges of `clk`. The third rising edge is the first one that can advance it.
- R3: At each rising edge with `clr` low and `count` below 12, `count` becomes its old value plus one.
- R4: At a rising edge with `clr` low and `count` equal to 12, `count` becomes 0. `count` never shows a value above 12, and the value 13 never appears.
- R5: `tc` is 1 exactly when `count` equals 12, and 0 for every other value.
- R6: At a rising edge with `clr` high, `count` becomes 0, whatever the count was, 12 included. The clear takes priority over the increment.
- R7: When counting runs free, successive cycles with `tc` high are exactly 13 clock edges apart.
- R8: While `clr` is held high across several edges, `count` stays at 0 and `tc` stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| clr | input | 1 | Synchronous clear, active high, forces the count to 0 |
| count | output | 4 | Current count value, 0 to 12 |
| tc | output | 1 | Terminal flag, high while the count is 12 |

## Verification
A decode mask set to the wrong bits shows up in one of two ways. The count escapes past 12, or it folds back early. Either way the error appears at the ports within one 13-state period, both as a wrong `count` value and as a shift in the spacing of `tc` pulses. A carry fault in the incrementer shows on the first edge that needs that carry, which is at most eight edges after a clear. A wrong clear priority shows on the edge where `clr` meets the count of 12. A synchronizer with the wrong depth moves the first increment after reset by at least one edge.

// File: rtl/mod13_pkg.sv
package mod13_pkg;

  // Default geometry of the counter.
  localparam int CNT_W   = 4;
  localparam int CNT_MOD = 13;

  // Number of flops used to release the asynchronous reset.
  localparam int RST_STAGES = 2;

  // Bits that are set in the first illegal state; the decode ANDs these.
  function automatic logic [CNT_W-1:0] detect_mask(input int modulus);
    detect_mask = CNT_W'(modulus);
  endfunction

endpackage

// File: rtl/mod13_rst_sync.sv
module mod13_rst_sync #(
  parameter int STAGES = mod13_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign core_rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mod13_bin_stages.sv
// Behavioural model of the binary count chain: stage 0 toggles every edge
// (the divide-by-2 section), and the upper stages form the divide-by-8
// section, each toggling when every stage below it is set.
module mod13_bin_stages #(
  parameter int WIDTH = mod13_pkg::CNT_W
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign nxt[i]     = cur[i] ^ carry[i];
    assign carry[i+1] = carry[i] & cur[i];
  end

endmodule

// File: rtl/mod13_state_detect.sv
// Decodes the first unwanted state from the incremented value and merges
// the external clear into one zero-load request. Also flags the last state.
module mod13_state_detect #(
  parameter int WIDTH   = mod13_pkg::CNT_W,
  parameter int MODULUS = mod13_pkg::CNT_MOD
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] nxt,
  input  logic             clr,
  output logic             zero_load,
  output logic             last_state
);

  localparam logic [WIDTH-1:0] MASK = WIDTH'(MODULUS);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic illegal_hit;

  // AND of only those bits that are ones in the illegal state.
  assign illegal_hit = &(nxt | ~MASK);
  assign zero_load   = illegal_hit | clr;
  assign last_state  = (cur == LAST);

endmodule

// File: rtl/mod13_counter.sv
module mod13_counter #(
  parameter int WIDTH   = mod13_pkg::CNT_W,
  parameter int MODULUS = mod13_pkg::CNT_MOD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [WIDTH-1:0] count,
  output logic             tc
);

  logic             core_rst_n;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic [WIDTH-1:0] inc_val;
  logic             zero_load;
  logic             last_state;
  logic             count_en;

  mod13_rst_sync #(
    .STAGES (mod13_pkg::RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  mod13_bin_stages #(
    .WIDTH (WIDTH)
  ) u_bin (
    .cur (count_q),
    .nxt (inc_val)
  );

  mod13_state_detect #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_detect (
    .cur        (count_q),
    .nxt        (inc_val),
    .clr        (clr),
    .zero_load  (zero_load),
    .last_state (last_state)
  );

  // The register advances on every edge once out of reset.
  assign count_en = 1'b1;

  always_comb begin
    count_d = count_q;
    if (count_en) begin
      if (zero_load) begin
        count_d = '0;
      end else begin
        count_d = inc_val;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
  assign tc    = last_state;

endmodule

// File: rtl/mod13_counter_chk.sv
module mod13_counter_chk #(
  parameter int WIDTH   = mod13_pkg::CNT_W,
  parameter int MODULUS = mod13_pkg::CNT_MOD
) (
  input logic             clk,
  input logic             core_rst_n,
  input logic             clr,
  input logic [WIDTH-1:0] count,
  input logic             tc
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    count <= LAST);

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!clr && count == LAST) |=> count == '0);

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!clr && count < LAST) |=> count == $past(count) + 1'b1);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    clr |=> count == '0);

  // R5
  tc_flag_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    tc == (count == LAST));

endmodule

bind mod13_counter mod13_counter_chk #(
  .WIDTH   (WIDTH),
  .MODULUS (MODULUS)
) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .clr        (clr),
  .count      (count),
  .tc         (tc)
);

// File: tb/mod13_counter_bench.sv
module mod13_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic [3:0] count;
  logic       tc;

  int n_checks;
  int n_fail;

  mod13_counter u_mod13_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .count (count),
    .tc    (tc)
  );

  // Vector fields: [9] clr, [8:5] expected count, [4] expected tc, [3:0] requirement.
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 4'd1,  1'b0, 4'd3}, {1'b0, 4'd2,  1'b0, 4'd3},
    {1'b0, 4'd3,  1'b0, 4'd3}, {1'b0, 4'd4,  1'b0, 4'd3},
    {1'b0, 4'd5,  1'b0, 4'd3}, {1'b0, 4'd6,  1'b0, 4'd3},
    {1'b0, 4'd7,  1'b0, 4'd3}, {1'b0, 4'd8,  1'b0, 4'd3},
    {1'b0, 4'd9,  1'b0, 4'd3}, {1'b0, 4'd10, 1'b0, 4'd3},
    {1'b0, 4'd11, 1'b0, 4'd3}, {1'b0, 4'd12, 1'b1, 4'd5},
    {1'b0, 4'd0,  1'b0, 4'd4}, {1'b0, 4'd1,  1'b0, 4'd3},
    {1'b0, 4'd2,  1'b0, 4'd3}, {1'b0, 4'd3,  1'b0, 4'd3},
    {1'b1, 4'd0,  1'b0, 4'd6}, {1'b0, 4'd1,  1'b0, 4'd3},
    {1'b0, 4'd2,  1'b0, 4'd3}, {1'b1, 4'd0,  1'b0, 4'd6},
    {1'b1, 4'd0,  1'b0, 4'd8}, {1'b0, 4'd1,  1'b0, 4'd3}
  };

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input logic [3:0] exp_cnt, input logic exp_tc, input string req);
    n_checks++;
    if (count !== exp_cnt || tc !== exp_tc) begin
      n_fail++;
      $display("FAIL %s: count=%0d tc=%0b expected count=%0d tc=%0b",
               req, count, tc, exp_cnt, exp_tc);
    end
  endtask

  task automatic step(input logic clr_v);
    clr = clr_v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int last_tc_edge;
    int edge_no;
    logic [3:0] exp;
    n_checks = 0;
    n_fail   = 0;
    rst_n = 1'b0;
    clr   = 1'b0;
    #3;
    check(4'd0, 1'b0, "R1 reset state");

    @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(1'b0);
    check(4'd0, 1'b0, "R2 first edge after release");
    step(1'b0);
    check(4'd0, 1'b0, "R2 second edge after release");
    step(1'b0);
    check(4'd1, 1'b0, "R2 third edge advances");
    step(1'b1);
    check(4'd0, 1'b0, "R6 clear to start table");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][9]);
      check(VEC[i][8:5], VEC[i][4], $sformatf("R%0d table vector %0d", VEC[i][3:0], i));
    end

    // Free run of 60 edges: range, sequence and tc spacing (R3 R4 R7)
    step(1'b1);
    exp = 4'd0;
    last_tc_edge = -1;
    for (int e = 1; e <= 60; e++) begin
      step(1'b0);
      exp = (exp == 4'd12) ? 4'd0 : exp + 4'd1;
      edge_no = e;
      check(exp, exp == 4'd12, "R4 free-run sequence");
      if (count > 4'd12) begin
        n_checks++;
        n_fail++;
        $display("FAIL R4: count=%0d expected at most 12", count);
      end
      if (tc) begin
        if (last_tc_edge >= 0) begin
          n_checks++;
          if (edge_no - last_tc_edge != 13) begin
            n_fail++;
            $display("FAIL R7: tc spacing=%0d expected 13", edge_no - last_tc_edge);
          end
        end
        last_tc_edge = edge_no;
      end
    end

    // Clear while at 12 (R6): free run ended at 60 -> count 8; step to 12
    for (int k = 0; k < 4; k++) step(1'b0);
    check(4'd12, 1'b1, "R5 at last state before clear");
    step(1'b1);
    check(4'd0, 1'b0, "R6 clear wins over wrap at 12");
    step(1'b1);
    step(1'b1);
    check(4'd0, 1'b0, "R8 clear held");

    // Asynchronous reset mid-sequence (R1)
    for (int k = 0; k < 5; k++) step(1'b0);
    check(4'd5, 1'b0, "R3 count before async reset");
    #2;
    rst_n = 1'b0;
    #1;
    check(4'd0, 1'b0, "R1 async reset mid-sequence");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule